// File: doc/BRIEF.md
# HDLC Frame Transmitter

The block takes 9-bit words from an external first-word-fall-through transmit FIFO and sends them as bit-oriented HDLC frames, one line bit per clock. Each frame gets an opening flag, the data octets least significant bit first, an optional frame check sequence (16-bit or 32-bit CRC, or none) and a closing flag. A zero is inserted after every run of five ones inside the data and check fields. Between frames the line carries either continuous flags or all ones. If the FIFO runs dry before the word marked as last, the block sends an abort of eight ones and returns to fill. The serial output can be NRZI coded, and a loopback selector hands the transmitted stream to the receive side in place of the line input.

The control is one state machine with six states. FILL sends the interframe fill; at the end of each fill octet, with the FIFO non-empty and clear-to-send high, it moves to OPEN. OPEN sends the opening flag and at its last bit pops the first word and moves to DATA (or to ABORT if the FIFO is empty). DATA shifts out octets, popping a new word after each octet; after the last-marked octet it goes to FCS, or straight to CLOSE when the check field is disabled; an empty FIFO at an octet boundary before the last word moves it to ABORT. FCS shifts out the complemented CRC and then goes to CLOSE. CLOSE sends the closing flag; at its last bit it goes directly to DATA when another frame is waiting and clear-to-send is high (the flag is shared), else to FILL. ABORT sends eight ones and goes back to FILL.

Top module: `hdlc_frame_tx`

## Requirements
- R1: Every frame starts and ends with the flag 01111110, sent as octet 0x7E least significant bit first (0,1,1,1,1,1,1,0); data octets are also sent least significant bit first; when a second frame is already waiting as a closing flag ends and `cts` is high, that flag also opens the next frame.
- R2: In the data and check fields a 0 is inserted after every five consecutive 1s, including after the final check or data bit just before the closing flag; flags, fill and abort bits are never stuffed.
- R3: With `crc_off` low the frame ends with a check field: `crc_sel`=1 gives a 32-bit CRC (reflected polynomial 0xEDB88320), `crc_sel`=0 a 16-bit CRC (reflected polynomial 0x8408), both preset to all ones, computed over the data bits in send order, sent complemented and lowest bit first; with `crc_off` high the check field is absent.
- R4: Between frames `fill_flags`=1 gives back-to-back flags (two zeros per eight bits) and `fill_flags`=0 gives continuous ones.
- R5: Bit 8 of a FIFO word marks its octet (bits 7:0) as the last of the frame; after it the check field and the closing flag follow.
- R6: If the FIFO is empty when the next octet of an unfinished frame is needed, eight ones are sent with `abort_active` high, `underflow` pulses for one cycle with the first of them, and the block returns to fill.
- R7: `rts` is high whenever the FIFO is non-empty or a frame or abort is in progress, and low otherwise.
- R8: A frame opens only if `cts` was high at the last fill bit before it; while a frame is on the line `cts_lost` is high in every bit period following a cycle in which `cts` was low, and the frame still completes.
- R9: With `nrzi_en`=1 a line bit 0 toggles `txd` and a 1 holds it; with `nrzi_en`=0 `txd` equals the line bit.
- R10: `rx_line` equals `txd` when `loop_en` is 1 and `rx_in` when it is 0.
- R11: `frame_active` is high exactly while opening-flag, data, check, stuffed and closing-flag bits are on `txd`, aligned with them, and never together with `abort_active`; after reset `txd` is 1 and all status outputs are 0.
- R12: `fifo_rd` pulses once per octet sent and never while `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_data | input | 9 | FIFO head word: bit 8 last-octet mark, bits 7:0 octet |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rd | output | 1 | Pop the FIFO head at this clock edge |
| crc_sel | input | 1 | 1: 32-bit check field, 0: 16-bit |
| crc_off | input | 1 | Omit the check field |
| fill_flags | input | 1 | 1: flag fill between frames, 0: ones fill |
| nrzi_en | input | 1 | NRZI coding of the output |
| loop_en | input | 1 | Route the transmit stream to `rx_line` |
| cts | input | 1 | Clear to send, active high |
| rx_in | input | 1 | Line receive data |
| txd | output | 1 | Serial transmit data |
| rx_line | output | 1 | Receive data toward the receiver |
| rts | output | 1 | Request to send, active high |
| frame_active | output | 1 | A frame bit is on `txd` |
| flag_active | output | 1 | A flag bit is on `txd` |
| abort_active | output | 1 | An abort bit is on `txd` |
| underflow | output | 1 | One-cycle pulse at the start of an underflow abort |
| cts_lost | output | 1 | Clear to send was low during a frame |

## Verification
The bit chosen in a cycle, and every status flag describing it, appear together one edge later, so a frame's first bit shows up two edges after the fill decision that sampled `cts`, while `fifo_rd` is combinational and acts on the same edge as its decision. The bench samples all outputs two nanoseconds after each falling edge, decodes NRZI from consecutive `txd` values, and compares every bit marked by `frame_active` in order against a queue of expected bits built from the flag, octet and CRC rules; abort bits, fill windows, pops and status pulses are counted over the same samples. Since the expected stream is matched by order rather than by absolute cycle, the up-to-eight-cycle wait for a fill octet to finish needs no prediction, and the queue must be empty when the frame ends.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_OPEN,
        ST_DATA,
        ST_FCS,
        ST_CLOSE,
        ST_ABORT
    } tx_state_t;

endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
    parameter logic [15:0] POLY16 = 16'h8408,
    parameter logic [31:0] POLY32 = 32'hEDB88320
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic upd,
    input  logic drain,
    input  logic wide,
    input  logic din,
    output logic fcs_bit
);
    logic [31:0] rem;
    logic [31:0] step;

    always_comb begin
        step = rem >> 1;
        if (!wide) step[31:15] = '0;
        if (rem[0] ^ din) step = step ^ (wide ? POLY32 : {16'h0000, POLY16});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rem <= '1;
        else if (init)  rem <= '1;
        else if (upd)   rem <= step;
        else if (drain) rem <= rem >> 1;
    end

    assign fcs_bit = ~rem[0];
endmodule

// File: rtl/hdlc_tx_line.sv
module hdlc_tx_line (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic nrzi_en,
    input  logic loop_en,
    input  logic rx_in,
    output logic txd,
    output logic rx_line
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       txd <= 1'b1;
        else if (nrzi_en) txd <= bit_in ? txd : ~txd;
        else              txd <= bit_in;
    end

    assign rx_line = loop_en ? txd : rx_in;
endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
    import hdlc_tx_pkg::*;
#(
    parameter int          OCTET_W   = 8,
    parameter int          STUFF_RUN = 5,
    parameter int          ABORT_LEN = 8,
    parameter logic [7:0]  FLAG_PAT  = 8'h7E,
    parameter logic [15:0] POLY16    = 16'h8408,
    parameter logic [31:0] POLY32    = 32'hEDB88320
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OCTET_W:0]   fifo_data,
    input  logic               fifo_empty,
    output logic               fifo_rd,
    input  logic               crc_sel,
    input  logic               crc_off,
    input  logic               fill_flags,
    input  logic               nrzi_en,
    input  logic               loop_en,
    input  logic               cts,
    input  logic               rx_in,
    output logic               txd,
    output logic               rx_line,
    output logic               rts,
    output logic               frame_active,
    output logic               flag_active,
    output logic               abort_active,
    output logic               underflow,
    output logic               cts_lost
);
    localparam int IDX_W  = $clog2(ABORT_LEN > 8 ? ABORT_LEN : 8);
    localparam int ONES_W = $clog2(STUFF_RUN + 1);
    localparam int BC_W   = $clog2(OCTET_W);
    localparam int FCS16  = 16;
    localparam int FCS32  = 32;
    localparam int FCS_CW = $clog2(FCS32 + 1);

    tx_state_t            state, nxt;
    logic [IDX_W-1:0]     idx;
    logic [ONES_W-1:0]    ones;
    logic [BC_W-1:0]      bitcnt;
    logic [OCTET_W-1:0]   shreg;
    logic                 last_q;
    logic [FCS_CW-1:0]    fcs_left;
    logic                 bit_o, stuff, pop, c_init, c_upd, c_drain, fcs_bit;
    logic                 oct_end, bit_last, in_frame;

    assign oct_end  = (idx == IDX_W'(7));
    assign bit_last = (bitcnt == BC_W'(OCTET_W - 1));
    assign in_frame = state inside {ST_OPEN, ST_DATA, ST_FCS, ST_CLOSE};
    assign fifo_rd  = pop;
    assign rts      = !fifo_empty || (state != ST_FILL);

    // next state and line bit
    always_comb begin
        nxt     = state;
        bit_o   = 1'b1;
        pop     = 1'b0;
        c_init  = 1'b0;
        c_upd   = 1'b0;
        c_drain = 1'b0;
        stuff   = ((state == ST_DATA) || (state == ST_FCS) ||
                   (state == ST_CLOSE && idx == '0)) && (ones == ONES_W'(STUFF_RUN));
        unique case (state)
            ST_FILL: begin
                bit_o = fill_flags ? FLAG_PAT[idx[2:0]] : 1'b1;
                if (oct_end && !fifo_empty && cts) nxt = ST_OPEN;
            end
            ST_OPEN: begin
                bit_o = FLAG_PAT[idx[2:0]];
                if (oct_end) begin
                    if (fifo_empty) nxt = ST_ABORT;
                    else begin
                        pop = 1'b1; c_init = 1'b1; nxt = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (stuff) bit_o = 1'b0;
                else begin
                    bit_o = shreg[0];
                    c_upd = 1'b1;
                    if (bit_last) begin
                        if (last_q)          nxt = crc_off ? ST_CLOSE : ST_FCS;
                        else if (fifo_empty) nxt = ST_ABORT;
                        else                 pop = 1'b1;
                    end
                end
            end
            ST_FCS: begin
                if (stuff) bit_o = 1'b0;
                else begin
                    bit_o   = fcs_bit;
                    c_drain = 1'b1;
                    if (fcs_left == FCS_CW'(1)) nxt = ST_CLOSE;
                end
            end
            ST_CLOSE: begin
                if (stuff) bit_o = 1'b0;
                else begin
                    bit_o = FLAG_PAT[idx[2:0]];
                    if (oct_end) begin
                        if (!fifo_empty && cts) begin
                            pop = 1'b1; c_init = 1'b1; nxt = ST_DATA;
                        end else nxt = ST_FILL;
                    end
                end
            end
            ST_ABORT: begin
                bit_o = 1'b1;
                if (idx == IDX_W'(ABORT_LEN - 1)) nxt = ST_FILL;
            end
            default: nxt = ST_FILL;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_FILL;
            idx      <= '0;
            ones     <= '0;
            bitcnt   <= '0;
            shreg    <= '0;
            last_q   <= 1'b0;
            fcs_left <= '0;
        end else begin
            state <= nxt;
            if (nxt != state || (state == ST_FILL && oct_end))
                idx <= '0;
            else if (!stuff && (state inside {ST_FILL, ST_OPEN, ST_CLOSE, ST_ABORT}))
                idx <= idx + 1'b1;

            if ((state == ST_DATA || state == ST_FCS) && !stuff && bit_o)
                ones <= ones + 1'b1;
            else
                ones <= '0;

            if (pop) begin
                shreg  <= fifo_data[OCTET_W-1:0];
                last_q <= fifo_data[OCTET_W];
                bitcnt <= '0;
            end else if (state == ST_DATA && !stuff) begin
                shreg  <= shreg >> 1;
                bitcnt <= bitcnt + 1'b1;
            end

            if (state == ST_DATA && nxt == ST_FCS)
                fcs_left <= crc_sel ? FCS_CW'(FCS32) : FCS_CW'(FCS16);
            else if (state == ST_FCS && !stuff)
                fcs_left <= fcs_left - 1'b1;
        end
    end

    // status outputs, aligned with the bit on txd
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_active <= 1'b0;
            flag_active  <= 1'b0;
            abort_active <= 1'b0;
            underflow    <= 1'b0;
            cts_lost     <= 1'b0;
        end else begin
            frame_active <= in_frame;
            flag_active  <= (state == ST_OPEN) || (state == ST_CLOSE && !stuff) ||
                            (state == ST_FILL && fill_flags);
            abort_active <= (state == ST_ABORT);
            underflow    <= (state == ST_ABORT) && (idx == '0);
            cts_lost     <= in_frame && !cts;
        end
    end

    hdlc_tx_crc #(.POLY16(POLY16), .POLY32(POLY32)) u_crc (
        .clk(clk), .rst_n(rst_n), .init(c_init), .upd(c_upd), .drain(c_drain),
        .wide(crc_sel), .din(shreg[0]), .fcs_bit(fcs_bit)
    );

    hdlc_tx_line u_line (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_o), .nrzi_en(nrzi_en),
        .loop_en(loop_en), .rx_in(rx_in), .txd(txd), .rx_line(rx_line)
    );
endmodule

// File: rtl/hdlc_frame_tx_chk.sv
module hdlc_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic fifo_empty,
    input logic fifo_rd,
    input logic cts,
    input logic nrzi_en,
    input logic txd,
    input logic rts,
    input logic frame_active,
    input logic abort_active,
    input logic underflow,
    input logic cts_lost
);
    p_pop_nonempty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    p_rts_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_empty |-> rts);

    p_start_cts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_active) |-> $past(cts, 2));

    p_lost_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cts_lost |-> frame_active);

    p_uf_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> abort_active);

    p_abort_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_active && !$past(nrzi_en)) |-> txd);

    p_abort_nrzi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_active && $past(nrzi_en)) |-> $stable(txd));

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_active, abort_active}));
endmodule

bind hdlc_frame_tx hdlc_frame_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
    .cts(cts), .nrzi_en(nrzi_en), .txd(txd), .rts(rts),
    .frame_active(frame_active), .abort_active(abort_active),
    .underflow(underflow), .cts_lost(cts_lost)
);

// File: tb/hdlc_frame_tx_test.sv
`timescale 1ns/1ps
module hdlc_frame_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] fifo_data = '0;
    logic       fifo_empty = 1'b1;
    logic       fifo_rd;
    logic       crc_sel = 1'b0, crc_off = 1'b0, fill_flags = 1'b0;
    logic       nrzi_en = 1'b0, loop_en = 1'b0, cts = 1'b1, rx_in = 1'b0;
    logic       txd, rx_line, rts, frame_active, flag_active;
    logic       abort_active, underflow, cts_lost;

    int nchk = 0, nfail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hdlc_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
        .fifo_rd(fifo_rd), .crc_sel(crc_sel), .crc_off(crc_off),
        .fill_flags(fill_flags), .nrzi_en(nrzi_en), .loop_en(loop_en), .cts(cts),
        .rx_in(rx_in), .txd(txd), .rx_line(rx_line), .rts(rts),
        .frame_active(frame_active), .flag_active(flag_active),
        .abort_active(abort_active), .underflow(underflow), .cts_lost(cts_lost)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    endtask

    // FIFO model (first word falls through)
    logic [8:0] fq[$];
    bit pend_pop = 0;
    int pops = 0;
    always @(negedge clk) begin
        if (pend_pop && fq.size() > 0) begin
            void'(fq.pop_front());
            pops++;
        end
        fifo_empty = (fq.size() == 0);
        fifo_data  = (fq.size() > 0) ? fq[0] : 9'h000;
        #1;
        pend_pop = (fifo_rd === 1'b1);
    end

    // monitor: decode and compare every frame bit
    bit   expq[$];
    logic nrzi_edge = 1'b0;
    logic prev_txd = 1'b1, prev_fa = 1'b0, prev_ab = 1'b0;
    int   zero_cnt = 0, rises = 0, falls = 0, uf_cnt = 0, lost_cnt = 0;
    int   ab_len = 0, last_ab_len = 0;
    always @(posedge clk) nrzi_edge <= nrzi_en;
    always @(negedge clk) begin
        logic dec;
        if (rst_n) begin
            dec = nrzi_edge ? (txd == prev_txd) : txd;
            if (!dec) zero_cnt++;
            if (frame_active) begin
                if (expq.size() == 0) chk("R11 unexpected frame bit", 32'(dec), 32'h2);
                else chk("R1/R2/R3 frame bit", 32'(dec), 32'(expq.pop_front()));
            end
            if (abort_active) begin
                ab_len++;
                if (!dec) chk("R6 abort bit", 32'(dec), 32'h1);
            end
            if (prev_ab && !abort_active) begin
                last_ab_len = ab_len;
                ab_len = 0;
            end
            if (frame_active && !prev_fa) rises++;
            if (!frame_active && prev_fa) falls++;
            if (underflow) uf_cnt++;
            if (cts_lost) lost_cnt++;
            prev_fa = frame_active;
            prev_ab = abort_active;
        end
        prev_txd = txd;
    end

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    function automatic logic [31:0] fcs_of(input logic [7:0] d[$], input bit w32);
        logic [31:0] r32 = 32'hFFFF_FFFF;
        logic [15:0] r16 = 16'hFFFF;
        foreach (d[i]) begin
            for (int b = 0; b < 8; b++) begin
                logic fb32, fb16;
                fb32 = r32[0] ^ d[i][b];
                fb16 = r16[0] ^ d[i][b];
                r32 = (r32 >> 1) ^ (fb32 ? 32'hEDB88320 : 32'h0);
                r16 = (r16 >> 1) ^ (fb16 ? 16'h8408 : 16'h0);
            end
        end
        return w32 ? ~r32 : {16'h0000, ~r16};
    endfunction

    task automatic add_flag();
        for (int b = 0; b < 8; b++) expq.push_back(bit'((8'h7E >> b) & 8'h01));
    endtask

    task automatic add_body(input logic [7:0] d[$], input bit use_fcs, input bit w32);
        bit raw[$];
        int ones = 0;
        logic [31:0] f;
        foreach (d[i]) for (int b = 0; b < 8; b++) raw.push_back(d[i][b]);
        if (use_fcs) begin
            f = fcs_of(d, w32);
            for (int b = 0; b < (w32 ? 32 : 16); b++) raw.push_back(f[b]);
        end
        foreach (raw[i]) begin
            expq.push_back(raw[i]);
            if (raw[i]) begin
                ones++;
                if (ones == 5) begin
                    expq.push_back(1'b0);
                    ones = 0;
                end
            end else ones = 0;
        end
    endtask

    task automatic push_words(input logic [7:0] d[$], input bit mark_last);
        foreach (d[i]) fq.push_back({mark_last && (i == d.size() - 1), d[i]});
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        step();
        while (!(expq.size() == 0 && fq.size() == 0 && !frame_active && !abort_active) && t < 3000) begin
            step();
            t++;
        end
        repeat (3) step();
        chk({tag, " frame finished"}, 32'(t < 3000), 32'h1);
        chk({tag, " expected bits used"}, 32'(expq.size()), 32'h0);
    endtask

    task automatic run_frame(input string tag, input logic [7:0] d[$], input bit use_fcs, input bit w32);
        crc_off = !use_fcs;
        crc_sel = w32;
        add_flag();
        add_body(d, use_fcs, w32);
        add_flag();
        push_words(d, 1'b1);
        wait_done(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired (R1..R12 incomplete)");
        finish_run();
    end

    initial begin
        logic [7:0] d[$];
        logic [7:0] d2[$];
        int z0, p0, r0, f0, u0;
        logic a;

        repeat (4) step();
        rst_n = 1'b1;
        step();
        // R11 reset state
        chk("R11 txd after reset", 32'(txd), 32'h1);
        chk("R11 frame_active after reset", 32'(frame_active), 32'h0);
        chk("R11 abort_active after reset", 32'(abort_active), 32'h0);
        chk("R11 underflow after reset", 32'(underflow), 32'h0);
        chk("R7 rts idle", 32'(rts), 32'h0);
        chk("R12 no pop when empty", 32'(fifo_rd), 32'h0);

        // R4 ones fill
        repeat (10) step();
        z0 = zero_cnt;
        repeat (64) step();
        chk("R4 ones fill zeros", 32'(zero_cnt - z0), 32'h0);

        // R4 flag fill
        fill_flags = 1'b1;
        repeat (16) step();
        z0 = zero_cnt;
        repeat (64) step();
        chk("R4 flag fill zeros", 32'(zero_cnt - z0), 32'd16);

        // R1 R3 R5 R12: 16-bit check, classic test string
        d = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        p0 = pops;
        run_frame("R3 crc16", d, 1'b1, 1'b0);
        chk("R12 one pop per octet", 32'(pops - p0), 32'd9);

        // R2 R3: 32-bit check with long runs of ones
        d = '{8'hFF, 8'hFF, 8'h7E, 8'h3E, 8'hF8};
        run_frame("R2 crc32 stuffing", d, 1'b1, 1'b1);

        // R2 R3: no check field, data ends in five ones (stuff before flag)
        d = '{8'h0F, 8'hF8};
        run_frame("R3 crc_off trailing stuff", d, 1'b0, 1'b0);

        // R1: back-to-back frames share one flag
        crc_off = 1'b0;
        crc_sel = 1'b0;
        d  = '{8'hA5, 8'h5A, 8'hC3};
        d2 = '{8'h01, 8'h80};
        add_flag(); add_body(d, 1'b1, 1'b0);
        add_flag(); add_body(d2, 1'b1, 1'b0);
        add_flag();
        r0 = rises; f0 = falls;
        push_words(d, 1'b1);
        push_words(d2, 1'b1);
        wait_done("R1 shared flag");
        chk("R1 shared flag single active window (rises)", 32'(rises - r0), 32'h1);
        chk("R1 shared flag single active window (falls)", 32'(falls - f0), 32'h1);

        // R9 NRZI, ones fill first
        fill_flags = 1'b0;
        nrzi_en = 1'b1;
        repeat (4) step();
        a = txd;
        repeat (6) step();
        chk("R9 nrzi ones hold line", 32'(txd), 32'(a));
        d = '{8'h00, 8'h55, 8'hFF};
        run_frame("R9 nrzi frame", d, 1'b1, 1'b1);
        repeat (4) step();
        nrzi_en = 1'b0;
        repeat (4) step();

        // R8 R7: start held off by cts
        cts = 1'b0;
        r0 = rises;
        d = '{8'h12, 8'h34};
        crc_off = 1'b0; crc_sel = 1'b0;
        add_flag(); add_body(d, 1'b1, 1'b0); add_flag();
        push_words(d, 1'b1);
        repeat (40) step();
        chk("R8 no frame without cts", 32'(rises - r0), 32'h0);
        chk("R7 rts with pending word", 32'(rts), 32'h1);
        cts = 1'b1;
        wait_done("R8 start after cts");

        // R8 cts lost during a frame
        d = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h70, 8'h80, 8'h90, 8'hA0};
        crc_off = 1'b0; crc_sel = 1'b1;
        add_flag(); add_body(d, 1'b1, 1'b1); add_flag();
        push_words(d, 1'b1);
        u0 = lost_cnt;
        begin
            int t = 0;
            while (!frame_active && t < 100) begin step(); t++; end
        end
        repeat (20) step();
        cts = 1'b0;
        repeat (3) step();
        cts = 1'b1;
        wait_done("R8 cts lost");
        chk("R8 cts_lost reported", 32'(lost_cnt - u0 > 0), 32'h1);

        // R6 underflow abort
        u0 = uf_cnt;
        crc_off = 1'b0; crc_sel = 1'b0;
        d = '{8'h55};
        add_flag(); add_body(d, 1'b0, 1'b0);
        push_words(d, 1'b0);
        wait_done("R6 underflow");
        chk("R6 underflow pulses", 32'(uf_cnt - u0), 32'h1);
        chk("R6 abort length", 32'(last_ab_len), 32'd8);
        chk("R7 rts released after abort", 32'(rts), 32'h0);

        // R10 loopback
        loop_en = 1'b1;
        fill_flags = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step();
            chk("R10 loopback follows txd", 32'(rx_line), 32'(txd));
        end
        loop_en = 1'b0;
        rx_in = 1'b1;
        step();
        chk("R10 line input high", 32'(rx_line), 32'h1);
        rx_in = 1'b0;
        step();
        chk("R10 line input low", 32'(rx_line), 32'h0);

        repeat (5) step();
        finish_run();
    end
endmodule